// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This block holds the exception-related part of a floating-point status and control register. After every arithmetic operation the execution pipeline presents five raw exception indications (invalid, divide-by-zero, overflow, underflow, inexact) together with an update strobe. The unit overwrites the flag field with those indications and accumulates them into the sticky cause field. If any accumulated cause bit meets a set enable bit, it issues a one-cycle exception request with a fixed vector code.

Software can replace the whole register in one cycle. The written value passes through a fixed mask of writable bits. Two mode outputs are decoded from the stored value: a round-toward-zero select and a denormal flush-to-zero enable. Compare results also pass through the unit. An unordered compare takes the same status update path as an arithmetic result. An ordered compare only sets or clears the condition bit (T).

Top module: `fp_exc_status`

## Requirements
- R1: After reset, statusReg is 0 and excReq, excCode, tBit, roundToZero and flushDenorm are all 0.
- R2: On an update, the flag field statusReg[6:2] is replaced by excRaw. excRaw bit 0 is inexact, 1 underflow, 2 overflow, 3 divide-by-zero and 4 invalid, and they land at bits 2, 3, 4, 5 and 6.
- R3: On an update, the cause field statusReg[16:12] becomes its old value ORed with excRaw, in the same bit order. Bit 17 and every bit outside the flag and cause fields keep their value.
- R4: excReq is high in the cycle after an update exactly when excRaw is non-zero and the new cause bits [16:12] ANDed with the enable bits [11:7] are non-zero. While excReq is high, excCode is 0x120; otherwise excCode is 0.
- R5: An update with excRaw all zero leaves the flag field cleared, the cause field unchanged and excReq low.
- R6: A load sets statusReg to loadData ANDed with WR_MASK (default 0x003FFFFF) and never raises excReq.
- R7: A load in the same cycle as an update or compare wins, and the other request is dropped. An arithmetic update in the same cycle as a compare wins, and the compare is dropped.
- R8: roundToZero is 1 exactly when statusReg[1:0] equals 2'b01.
- R9: flushDenorm follows statusReg[18].
- R10: A compare with cmpUnordered set performs the same status update as R2 to R5 using excRaw, and leaves tBit unchanged.
- R11: An ordered compare sets tBit to cmpEqual when cmpKind is 0, or to cmpGreater when cmpKind is 1. It leaves statusReg unchanged and excReq low.
- R12: In a cycle with no load, update or compare, statusReg and tBit hold and excReq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | Software load strobe |
| loadData | input | 32 | Value to load (masked) |
| opValid | input | 1 | Arithmetic result update strobe |
| excRaw | input | 5 | Raw exception indications {V,Z,O,U,I} |
| cmpValid | input | 1 | Compare result strobe |
| cmpUnordered | input | 1 | Compare found operands unordered |
| cmpKind | input | 1 | 0 = equality compare, 1 = greater-than compare |
| cmpEqual | input | 1 | Operands compared equal |
| cmpGreater | input | 1 | First operand greater |
| statusReg | output | 32 | Current register value |
| excReq | output | 1 | One-cycle exception request |
| excCode | output | 12 | Vector code, 0x120 during excReq |
| tBit | output | 1 | Condition bit from ordered compares |
| roundToZero | output | 1 | Round-toward-zero select |
| flushDenorm | output | 1 | Denormal flush-to-zero enable |

## Verification
The bench targets the sticky nature of the cause field. It sends an update whose own raw bits are not enabled after an earlier update left an enabled cause bit set. A design that tested only the fresh flags against the enables would miss that request, and one that overwrote the cause field would lose the earlier bit. It also sends all-zero updates, which must still wipe the flags but raise nothing. It drives loads of all ones, which expose a wrong write mask, and cycles where load, update and compare collide, which expose a wrong priority order. Ordered and unordered compares are interleaved with updates, so a design that touches tBit on an unordered compare, or touches the status on an ordered one, diverges from the reference model.

// File: rtl/fpes_pkg.sv
package fpes_pkg;

  // Which request the control side granted this cycle
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_LOAD   = 2'd1,
    SRC_UPDATE = 2'd2,
    SRC_CMPT   = 2'd3
  } fpesSrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic doLoad;
    logic doUpdate;
    logic doSetT;
    logic tValue;
  } fpesStrobe_t;

endpackage

// File: rtl/fpes_ctrl.sv
module fpes_ctrl
  import fpes_pkg::*;
(
  input  logic        loadValid,
  input  logic        opValid,
  input  logic        cmpValid,
  input  logic        cmpUnordered,
  input  logic        cmpKind,
  input  logic        cmpEqual,
  input  logic        cmpGreater,
  output fpesStrobe_t strobe
);

  fpesSrc_e grant;
  logic     orderedT;

  // Priority: software load, then arithmetic update, then compare
  always_comb begin
    if (loadValid)
      grant = SRC_LOAD;
    else if (opValid)
      grant = SRC_UPDATE;
    else if (cmpValid && cmpUnordered)
      grant = SRC_UPDATE;
    else if (cmpValid)
      grant = SRC_CMPT;
    else
      grant = SRC_NONE;
  end

  // Ordered compare result selected by compare kind
  assign orderedT = cmpKind ? cmpGreater : cmpEqual;

  always_comb begin
    strobe          = '0;
    strobe.doLoad   = (grant == SRC_LOAD);
    strobe.doUpdate = (grant == SRC_UPDATE);
    strobe.doSetT   = (grant == SRC_CMPT);
    strobe.tValue   = orderedT;
  end

endmodule

// File: rtl/fpes_datapath.sv
module fpes_datapath
  import fpes_pkg::*;
#(
  parameter int              REG_W     = 32,
  parameter int              EXC_N     = 5,
  parameter int              FLAG_LSB  = 2,
  parameter int              ENA_LSB   = 7,
  parameter int              CAUSE_LSB = 12,
  parameter int              DN_BIT    = 18,
  parameter int              RM_W      = 2,
  parameter logic [RM_W-1:0] RM_ZERO   = 2'b01,
  parameter logic [REG_W-1:0] WR_MASK  = 32'h003F_FFFF,
  parameter int              CODE_W    = 12,
  parameter logic [CODE_W-1:0] VEC_CODE = 12'h120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fpesStrobe_t       strobe,
  input  logic [REG_W-1:0]  loadData,
  input  logic [EXC_N-1:0]  excRaw,
  output logic [REG_W-1:0]  statusReg,
  output logic              excReq,
  output logic [CODE_W-1:0] excCode,
  output logic              tBit,
  output logic              roundToZero,
  output logic              flushDenorm
);

  logic [EXC_N-1:0] flagNew;
  logic [EXC_N-1:0] causeNew;
  logic [EXC_N-1:0] enaCur;
  logic [EXC_N-1:0] trapHit;
  logic [REG_W-1:0] regUpd;
  logic [REG_W-1:0] regNext;
  logic             reqNext;
  logic             tNext;

  // Per-exception bit slice: clear-and-set flag, sticky cause, enable match
  for (genvar gi = 0; gi < EXC_N; gi++) begin : g_exc
    assign flagNew[gi]  = excRaw[gi];
    assign causeNew[gi] = statusReg[CAUSE_LSB + gi] | excRaw[gi];
    assign enaCur[gi]   = statusReg[ENA_LSB + gi];
    assign trapHit[gi]  = causeNew[gi] & enaCur[gi];
  end

  always_comb begin
    regUpd                         = statusReg;
    regUpd[FLAG_LSB +: EXC_N]      = flagNew;
    regUpd[CAUSE_LSB +: EXC_N]     = causeNew;
  end

  always_comb begin
    regNext = statusReg;
    reqNext = 1'b0;
    tNext   = tBit;
    if (strobe.doLoad) begin
      regNext = loadData & WR_MASK;
    end else if (strobe.doUpdate) begin
      regNext = regUpd;
      reqNext = (|excRaw) && (|trapHit);
    end else if (strobe.doSetT) begin
      tNext = strobe.tValue;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statusReg <= '0;
      excReq    <= 1'b0;
      tBit      <= 1'b0;
    end else begin
      statusReg <= regNext;
      excReq    <= reqNext;
      tBit      <= tNext;
    end
  end

  assign excCode     = excReq ? VEC_CODE : '0;
  assign roundToZero = (statusReg[RM_W-1:0] == RM_ZERO);
  assign flushDenorm = statusReg[DN_BIT];

endmodule

// File: rtl/fp_exc_status.sv
module fp_exc_status
  import fpes_pkg::*;
#(
  parameter int               REG_W     = 32,
  parameter int               EXC_N     = 5,
  parameter int               FLAG_LSB  = 2,
  parameter int               ENA_LSB   = 7,
  parameter int               CAUSE_LSB = 12,
  parameter int               DN_BIT    = 18,
  parameter logic [REG_W-1:0] WR_MASK   = 32'h003F_FFFF,
  parameter int               CODE_W    = 12,
  parameter logic [CODE_W-1:0] VEC_CODE = 12'h120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadValid,
  input  logic [REG_W-1:0]  loadData,
  input  logic              opValid,
  input  logic [EXC_N-1:0]  excRaw,
  input  logic              cmpValid,
  input  logic              cmpUnordered,
  input  logic              cmpKind,
  input  logic              cmpEqual,
  input  logic              cmpGreater,
  output logic [REG_W-1:0]  statusReg,
  output logic              excReq,
  output logic [CODE_W-1:0] excCode,
  output logic              tBit,
  output logic              roundToZero,
  output logic              flushDenorm
);

  fpesStrobe_t strobe;

  fpes_ctrl u_ctrl (
    .loadValid    (loadValid),
    .opValid      (opValid),
    .cmpValid     (cmpValid),
    .cmpUnordered (cmpUnordered),
    .cmpKind      (cmpKind),
    .cmpEqual     (cmpEqual),
    .cmpGreater   (cmpGreater),
    .strobe       (strobe)
  );

  fpes_datapath #(
    .REG_W     (REG_W),
    .EXC_N     (EXC_N),
    .FLAG_LSB  (FLAG_LSB),
    .ENA_LSB   (ENA_LSB),
    .CAUSE_LSB (CAUSE_LSB),
    .DN_BIT    (DN_BIT),
    .WR_MASK   (WR_MASK),
    .CODE_W    (CODE_W),
    .VEC_CODE  (VEC_CODE)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .loadData    (loadData),
    .excRaw      (excRaw),
    .statusReg   (statusReg),
    .excReq      (excReq),
    .excCode     (excCode),
    .tBit        (tBit),
    .roundToZero (roundToZero),
    .flushDenorm (flushDenorm)
  );

endmodule

// File: rtl/fpes_chk.sv
module fpes_chk #(
  parameter int               REG_W     = 32,
  parameter int               EXC_N     = 5,
  parameter int               FLAG_LSB  = 2,
  parameter int               CAUSE_LSB = 12,
  parameter logic [REG_W-1:0] WR_MASK   = 32'h003F_FFFF,
  parameter int               CODE_W    = 12,
  parameter logic [CODE_W-1:0] VEC_CODE = 12'h120
) (
  input logic              clk,
  input logic              rst_n,
  input logic              loadValid,
  input logic [REG_W-1:0]  loadData,
  input logic              opValid,
  input logic [EXC_N-1:0]  excRaw,
  input logic              cmpValid,
  input logic              cmpUnordered,
  input logic [REG_W-1:0]  statusReg,
  input logic              excReq,
  input logic [CODE_W-1:0] excCode,
  input logic              tBit
);

  logic updIn;
  logic cmpOnly;
  logic idle;

  assign updIn   = !loadValid && (opValid || (cmpValid && cmpUnordered));
  assign cmpOnly = !loadValid && !opValid && cmpValid && !cmpUnordered;
  assign idle    = !loadValid && !opValid && !cmpValid;

  // R2
  flag_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updIn |=> statusReg[FLAG_LSB +: EXC_N] == $past(excRaw));

  // R3
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updIn |=> statusReg[CAUSE_LSB +: EXC_N] ==
              ($past(statusReg[CAUSE_LSB +: EXC_N]) | $past(excRaw)));

  // R4
  req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    excReq |-> $past(updIn) && ($past(excRaw) != '0));

  // R4
  code_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    excCode == (excReq ? VEC_CODE : '0));

  // R5
  zero_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (updIn && excRaw == '0) |=> !excReq && $stable(statusReg[CAUSE_LSB +: EXC_N]));

  // R6
  load_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loadValid |=> statusReg == ($past(loadData) & WR_MASK) && !excReq);

  // R11
  ordered_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpOnly |=> $stable(statusReg) && !excReq);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(statusReg) && $stable(tBit) && !excReq);

endmodule

bind fp_exc_status fpes_chk #(
  .REG_W     (REG_W),
  .EXC_N     (EXC_N),
  .FLAG_LSB  (FLAG_LSB),
  .CAUSE_LSB (CAUSE_LSB),
  .WR_MASK   (WR_MASK),
  .CODE_W    (CODE_W),
  .VEC_CODE  (VEC_CODE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .loadValid    (loadValid),
  .loadData     (loadData),
  .opValid      (opValid),
  .excRaw       (excRaw),
  .cmpValid     (cmpValid),
  .cmpUnordered (cmpUnordered),
  .statusReg    (statusReg),
  .excReq       (excReq),
  .excCode      (excCode),
  .tBit         (tBit)
);

// File: tb/fp_exc_status_test.sv
`timescale 1ns/1ps
module fp_exc_status_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loadValid = 1'b0;
  logic [31:0] loadData = '0;
  logic        opValid = 1'b0;
  logic [4:0]  excRaw = '0;
  logic        cmpValid = 1'b0;
  logic        cmpUnordered = 1'b0;
  logic        cmpKind = 1'b0;
  logic        cmpEqual = 1'b0;
  logic        cmpGreater = 1'b0;
  logic [31:0] statusReg;
  logic        excReq;
  logic [11:0] excCode;
  logic        tBit;
  logic        roundToZero;
  logic        flushDenorm;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  // Reference model state
  logic [31:0] mReg = '0;
  logic        mT = 1'b0;
  logic        mReq = 1'b0;
  string       mTag = "R1";

  always #4 clk = ~clk;

  fp_exc_status uut (
    .clk(clk), .rst_n(rst_n),
    .loadValid(loadValid), .loadData(loadData),
    .opValid(opValid), .excRaw(excRaw),
    .cmpValid(cmpValid), .cmpUnordered(cmpUnordered), .cmpKind(cmpKind),
    .cmpEqual(cmpEqual), .cmpGreater(cmpGreater),
    .statusReg(statusReg), .excReq(excReq), .excCode(excCode), .tBit(tBit),
    .roundToZero(roundToZero), .flushDenorm(flushDenorm)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Model advance for one clock edge, from the requirement text
  task automatic modelStep();
    int causeV, enaV, rawV;
    rawV = int'(excRaw);
    if (loadValid) begin
      mReg = loadData & 32'h003F_FFFF;
      mReq = 1'b0;
      mTag = (opValid || cmpValid) ? "R7" : "R6";
    end else if (opValid || (cmpValid && cmpUnordered)) begin
      causeV = int'(mReg[16:12]) | rawV;
      enaV   = int'(mReg[11:7]);
      mReg[6:2]   = excRaw;
      mReg[16:12] = causeV[4:0];
      mReq = (rawV != 0) && ((causeV & enaV) != 0);
      if (!opValid) mTag = "R10";
      else if (cmpValid) mTag = "R7";
      else if (rawV == 0) mTag = "R5";
      else mTag = "R4";
    end else if (cmpValid) begin
      mT = cmpKind ? cmpGreater : cmpEqual;
      mReq = 1'b0;
      mTag = "R11";
    end else begin
      mReq = 1'b0;
      mTag = "R12";
    end
  endtask

  task automatic compareAll();
    check(mTag, "statusReg R2/R3", longint'(statusReg), longint'(mReg));
    check(mTag, "excReq", longint'(excReq), longint'(mReq));
    check(mTag, "excCode", longint'(excCode), mReq ? 64'h120 : 64'h0);
    check(mTag, "tBit", longint'(tBit), longint'(mT));
    check("R8", "roundToZero", longint'(roundToZero), longint'(mReg[1:0] == 2'b01));
    check("R9", "flushDenorm", longint'(flushDenorm), longint'(mReg[18]));
  endtask

  task automatic cycle(input bit ld, input logic [31:0] d, input bit op, input logic [4:0] raw,
                       input bit cv, input bit un, input bit kd, input bit eq, input bit gt);
    @(negedge clk);
    loadValid = ld; loadData = d; opValid = op; excRaw = raw;
    cmpValid = cv; cmpUnordered = un; cmpKind = kd; cmpEqual = eq; cmpGreater = gt;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    loadValid = 0; opValid = 0; cmpValid = 0;
    compareAll();
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "statusReg", longint'(statusReg), 0);
    check("R1", "excReq", longint'(excReq), 0);
    check("R1", "excCode", longint'(excCode), 0);
    check("R1", "tBit", longint'(tBit), 0);
    check("R1", "roundToZero", longint'(roundToZero), 0);
    check("R1", "flushDenorm", longint'(flushDenorm), 0);

    // R6 mask with all ones, R8/R9 modes
    cycle(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0);
    // Enable only invalid (bit 11), round-to-zero, flush on
    cycle(1, 32'h0004_0801, 0, 0, 0, 0, 0, 0, 0);
    // R4 inexact only: not enabled, no request
    cycle(0, 0, 1, 5'b00001, 0, 0, 0, 0, 0);
    // R4 invalid: enabled, request
    cycle(0, 0, 1, 5'b10000, 0, 0, 0, 0, 0);
    // R4 sticky cause: overflow raw, invalid cause still set -> request
    cycle(0, 0, 1, 5'b00100, 0, 0, 0, 0, 0);
    // R5 zero raw
    cycle(0, 0, 1, 5'b00000, 0, 0, 0, 0, 0);
    // R12 idle
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R11 ordered compares
    cycle(0, 0, 0, 5'b11111, 1, 0, 0, 1, 0);
    cycle(0, 0, 0, 0, 1, 0, 1, 1, 0);
    cycle(0, 0, 0, 0, 1, 0, 1, 0, 1);
    // R10 unordered compare
    cycle(0, 0, 0, 5'b10000, 1, 1, 0, 1, 1);
    // R7 collisions
    cycle(1, 32'h0000_0F80, 1, 5'b11111, 1, 0, 0, 1, 0);
    cycle(0, 0, 1, 5'b00010, 1, 0, 0, 0, 0);
    cycle(1, 32'h0000_0002, 0, 0, 1, 0, 0, 1, 0);

    // Mixed stimulus
    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom_range(0, 15);
      cycle(sel == 0, $urandom(), sel inside {[1:7]} || sel == 15, 5'($urandom()),
            sel inside {[6:12]}, $urandom_range(0, 2) == 0, 1'($urandom()),
            1'($urandom()), 1'($urandom()));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule